// File: doc/BRIEF.md
# Serial Clock-Register and Scratchpad Access Port

This block is the serial slave front end of a small timekeeping device. A host drives a four-wire serial bus with an active-low select, and the block decodes one leading command byte per transfer, then moves one data byte or a stream of data bytes. Eight clock-side registers sit behind it: seven calendar fields (seconds, minutes, hours, date, month, weekday, year) and one control byte. Next to them is a 31-byte user scratchpad.

Bus lines are brought into the system clock domain through flop chains. Bits are taken in on each rising serial clock edge and put out on each falling edge, MSB first. A burst of the clock registers runs through all eight in a fixed order. For a burst write, the incoming bytes are held in a staging area and copied into the live registers together, and only once the eighth byte is complete. A scratchpad burst commits every full byte as it arrives.

The timekeeping logic reads the eight live registers on a parallel bus and can load all eight at once. A one-cycle strobe tells it when a host write has changed them.

Top module: `rtc_spi_regfile`

## Requirements
- R1: After reset every calendar/control byte on `cal_q` is 00h, and `spi_miso` and `upd_stb` are low.
- R2: The command byte is decoded as follows. Bit 7 is 1 for a read and 0 for a write. Bit 6 is 1 for the scratchpad and 0 for clock space. Bits 5..1 are an index, and bit 0 must be 1 for a write to take effect. In clock space, indices 0..7 address seconds, minutes, hours, date, month, weekday, year and control, and a single-byte write or read reaches that register.
- R3: Clock-space indices 8..30 read as 00h, and writes to them change no register and raise no strobe.
- R4: When command bit 0 is 0, the transfer writes nothing to either space.
- R5: Clock-space index 31 is a burst. Its write takes bytes in register order 0..7 and updates all eight registers together in the cycle after the eighth byte completes.
- R6: A clock burst write that ends (select raised) before its eighth byte completes leaves all eight registers unchanged.
- R7: A clock burst read returns registers 0..7 in order, and any byte after the eighth reads 00h.
- R8: Scratchpad indices 0..30 are written and read as single bytes.
- R9: Scratchpad index 31 is a burst starting at location 0. Each complete byte is stored as it arrives, and a partial trailing byte is discarded.
- R10: A scratchpad burst read returns locations 0..30 in order, and later bytes read 00h.
- R11: A pulse on `tk_load` copies `tk_din` (byte k in bits 8k+7..8k) into the eight registers. This raises no strobe, and the new values are readable over the bus.
- R12: `upd_stb` is high for exactly one cycle per committed clock-space write (single or full burst).
- R13: Raising select mid-byte clears the bit counter, so the next transfer decodes its command from its own first eight bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, changes on falling serial clock |
| tk_load | input | 1 | Parallel load request from timekeeping logic |
| tk_din | input | 8*NCLK | Parallel load value, byte k for register k |
| cal_q | output | 8*NCLK | Live register values, byte k for register k |
| upd_stb | output | 1 | One-cycle pulse when a host write has committed |

## Verification
The serial input passes two synchronizer flops and one edge-detect flop, and the byte-complete flag and `spi_miso` are each one more register. A data bit therefore appears on `spi_miso` about four system cycles after the falling serial edge that releases it, and a committed write shows on `cal_q` about four cycles after the last rising edge. The bench holds each serial clock phase for eight system cycles and samples `spi_miso` just before it raises the serial clock. It reads `cal_q` and its count of strobe pulses only after select has been high for twenty-four cycles, so every result is settled before it is compared. The model covers sweeps over every register and scratchpad index, aborted and partial bursts, and the reads past the end of each burst.

// File: rtl/rtcs_pkg.sv
`timescale 1ns/1ps
package rtcs_pkg;
   localparam int BYTE_W = 8;
   localparam int IDX_W  = 5;
   localparam logic [IDX_W-1:0] BURST_IDX = '1;

   // command byte layout: read flag, space select, index, write-enable
   typedef struct packed {
      logic             rd;
      logic             ram;
      logic [IDX_W-1:0] idx;
      logic             wen;
   } cmd_t;
endpackage

// File: rtl/rtcs_sync.sv
`timescale 1ns/1ps
module rtcs_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rtcs_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] st [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      st[g] <= RST_VAL;
         else if (g == 0) st[g] <= d;
         else             st[g] <= st[(g == 0) ? 0 : g-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/rtcs_spi_shift.sv
`timescale 1ns/1ps
module rtcs_spi_shift #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sclk,
   input  logic       cs_n,
   input  logic       mosi,
   input  logic       tx_en,
   input  logic       tx_load,
   input  logic [7:0] tx_byte,
   output logic       cs_act,
   output logic       byte_vld,
   output logic [7:0] rx_byte,
   output logic       miso
);
   logic [2:0] s_bus;
   logic       sclk_d;
   logic [2:0] bit_cnt;
   logic [6:0] rx_sr;
   logic [7:0] tx_sr;

   rtcs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sclk, cs_n, mosi}), .q(s_bus)
   );

   assign cs_act = ~s_bus[1];
   wire rise = s_bus[2] & ~sclk_d & cs_act;
   wire fall = ~s_bus[2] & sclk_d & cs_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         bit_cnt  <= '0;
         rx_sr    <= '0;
         tx_sr    <= '0;
         rx_byte  <= '0;
         byte_vld <= 1'b0;
         miso     <= 1'b0;
      end else begin
         sclk_d   <= s_bus[2];
         byte_vld <= 1'b0;
         if (!cs_act) begin
            bit_cnt <= '0;
            miso    <= 1'b0;
         end else begin
            if (rise) begin
               rx_sr   <= {rx_sr[5:0], s_bus[0]};
               bit_cnt <= bit_cnt + 3'd1;
               if (bit_cnt == 3'd7) begin
                  byte_vld <= 1'b1;
                  rx_byte  <= {rx_sr, s_bus[0]};
               end
            end
            if (fall) begin
               if (tx_en) begin
                  miso  <= tx_sr[7];
                  tx_sr <= {tx_sr[6:0], 1'b0};
               end else begin
                  miso <= 1'b0;
               end
            end
            if (tx_load) tx_sr <= tx_byte;
         end
      end
   end

   a_r13_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (bit_cnt == 3'd0));
   a_r1_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !miso);
endmodule

// File: rtl/rtcs_ram.sv
`timescale 1ns/1ps
module rtcs_ram #(
   parameter int DEPTH = 31,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   localparam logic [AW:0] DEP = (AW+1)'(DEPTH);

   logic [7:0] mem [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            mem[g] <= '0;
         else if (we && waddr == AW'(g))        mem[g] <= wdata;
      end
   end

   assign rdata = ({1'b0, raddr} < DEP) ? mem[raddr] : 8'h00;

   a_r9_waddr_range: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> ({1'b0, waddr} < DEP));
endmodule

// File: rtl/rtc_spi_regfile.sv
`timescale 1ns/1ps
module rtc_spi_regfile
   import rtcs_pkg::*;
#(
   parameter int NCLK        = 8,
   parameter int RAM_DEPTH   = 31,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   input  logic              tk_load,
   input  logic [8*NCLK-1:0] tk_din,
   output logic [8*NCLK-1:0] cal_q,
   output logic              upd_stb
);
   localparam int PW = 6;
   localparam int CW = $clog2(NCLK);
   localparam int AW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;
   localparam logic [PW-1:0]    RAM_LIM  = PW'(RAM_DEPTH);
   localparam logic [PW-1:0]    CLK_LIM  = PW'(NCLK);
   localparam logic [PW-1:0]    CLK_LAST = PW'(NCLK - 1);
   localparam logic [IDX_W-1:0] RAM_ILIM = IDX_W'(RAM_DEPTH);
   localparam logic [IDX_W-1:0] CLK_ILIM = IDX_W'(NCLK);

   if (NCLK < 2 || NCLK > 31) begin : g_bad_nclk
      $error("rtc_spi_regfile: NCLK out of range");
   end
   if (RAM_DEPTH < 1 || RAM_DEPTH > 31) begin : g_bad_depth
      $error("rtc_spi_regfile: RAM_DEPTH out of range");
   end

   logic          cs_act, byte_vld;
   logic [7:0]    rx_byte, rd_byte, ram_rd;
   cmd_t          cmd_q;
   logic          have_cmd;
   logic [PW-1:0] ptr, sel_ptr;
   logic [7:0]    creg  [NCLK];
   logic [7:0]    stage [NCLK-1];

   rtcs_spi_shift #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
      .tx_en(have_cmd & cmd_q.rd), .tx_load(byte_vld), .tx_byte(rd_byte),
      .cs_act(cs_act), .byte_vld(byte_vld), .rx_byte(rx_byte), .miso(spi_miso)
   );

   // read side: the byte for the next slot is prepared when a byte completes
   logic             sel_ram, sel_burst;
   logic [IDX_W-1:0] sel_idx;
   logic [AW-1:0]    ram_raddr;
   always_comb begin
      sel_ram   = have_cmd ? cmd_q.ram : rx_byte[6];
      sel_idx   = have_cmd ? cmd_q.idx : rx_byte[5:1];
      sel_ptr   = !have_cmd ? '0 : ((ptr == '1) ? ptr : ptr + 1'b1);
      sel_burst = (sel_idx == BURST_IDX);
      ram_raddr = sel_burst ? sel_ptr[AW-1:0] : sel_idx[AW-1:0];
      rd_byte   = 8'h00;
      if (sel_ram) begin
         if (sel_burst ? (sel_ptr < RAM_LIM) : (sel_ptr == '0 && sel_idx < RAM_ILIM))
            rd_byte = ram_rd;
      end else if (sel_burst) begin
         if (sel_ptr < CLK_LIM) rd_byte = creg[sel_ptr[CW-1:0]];
      end else if (sel_ptr == '0 && sel_idx < CLK_ILIM) begin
         rd_byte = creg[sel_idx[CW-1:0]];
      end
   end

   // write side decode
   logic          wr_go, q_burst, ram_we, stg_we, burst_commit, single_wr;
   logic [AW-1:0] ram_waddr;
   always_comb begin
      wr_go        = byte_vld & have_cmd & ~cmd_q.rd & cmd_q.wen;
      q_burst      = (cmd_q.idx == BURST_IDX);
      ram_we       = wr_go & cmd_q.ram &
                     (q_burst ? (ptr < RAM_LIM) : (ptr == '0 && cmd_q.idx < RAM_ILIM));
      ram_waddr    = q_burst ? ptr[AW-1:0] : cmd_q.idx[AW-1:0];
      stg_we       = wr_go & ~cmd_q.ram & q_burst & (ptr < CLK_LAST);
      burst_commit = wr_go & ~cmd_q.ram & q_burst & (ptr == CLK_LAST);
      single_wr    = wr_go & ~cmd_q.ram & ~q_burst & (ptr == '0) & (cmd_q.idx < CLK_ILIM);
   end

   rtcs_ram #(.DEPTH(RAM_DEPTH)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_waddr), .wdata(rx_byte),
      .raddr(ram_raddr), .rdata(ram_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         have_cmd <= 1'b0;
         ptr      <= '0;
         upd_stb  <= 1'b0;
      end else begin
         upd_stb <= burst_commit | single_wr;
         if (byte_vld) begin
            if (!have_cmd) begin
               cmd_q    <= cmd_t'(rx_byte);
               have_cmd <= 1'b1;
               ptr      <= '0;
            end else if (ptr != '1) begin
               ptr <= ptr + 1'b1;
            end
         end else if (!cs_act) begin
            have_cmd <= 1'b0;
            ptr      <= '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NCLK; k++)   creg[k]  <= '0;
         for (int k = 0; k < NCLK-1; k++) stage[k] <= '0;
      end else begin
         if (!cs_act && !byte_vld)
            for (int k = 0; k < NCLK-1; k++) stage[k] <= '0;
         else if (stg_we)
            stage[ptr[CW-1:0]] <= rx_byte;
         if (burst_commit) begin
            for (int k = 0; k < NCLK-1; k++) creg[k] <= stage[k];
            creg[NCLK-1] <= rx_byte;
         end else if (single_wr) begin
            creg[cmd_q.idx[CW-1:0]] <= rx_byte;
         end else if (tk_load) begin
            for (int k = 0; k < NCLK; k++) creg[k] <= tk_din[8*k +: 8];
         end
      end
   end

   for (genvar g = 0; g < NCLK; g++) begin : g_out
      assign cal_q[8*g +: 8] = creg[g];
   end

   a_r12_upd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |=> !upd_stb);
   a_r4_protect_no_upd: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && have_cmd && !cmd_q.wen) |=> !upd_stb);
   a_r6_idle_no_upd: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_act && !byte_vld) |=> !upd_stb);
   a_r5_upd_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |-> $past(byte_vld));
   a_r11_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (tk_load && !byte_vld) |=> !upd_stb);
endmodule

// File: tb/rtc_spi_regfile_bench.sv
`timescale 1ns/1ps
module rtc_spi_regfile_bench;
   localparam int HALF = 8;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic        miso, tk_load = 1'b0, upd_stb;
   logic [63:0] tk_din = '0, cal_q;

   int n_chk = 0, n_bad = 0, upd_cnt = 0, upd_long = 0;
   logic [7:0] exp_cal [8];
   logic [7:0] exp_ram [31];
   logic       upd_prev = 1'b0;

   always #2 clk = ~clk;

   rtc_spi_regfile u_rtc_spi_regfile (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_miso(miso), .tk_load(tk_load), .tk_din(tk_din), .cal_q(cal_q), .upd_stb(upd_stb)
   );

   always @(posedge clk) begin
      if (rst_n && upd_stb) upd_cnt++;
      if (rst_n && upd_stb && upd_prev) upd_long++;
      upd_prev <= upd_stb;
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_cal(input string req);
      for (int k = 0; k < 8; k++) check(req, 64'(cal_q[8*k +: 8]), 64'(exp_cal[k]));
   endtask

   task automatic spi_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - nb; i--) begin
         mosi = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i] = miso;
         sclk = 1'b1;
         repeat (HALF) @(negedge clk);
         sclk = 1'b0;
      end
   endtask

   task automatic cs_lo();
      @(negedge clk) cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_hi();
      repeat (HALF) @(negedge clk);
      cs_n = 1'b1;
      repeat (3*HALF) @(negedge clk);
   endtask

   task automatic wr1(input logic [7:0] cmd, input logic [7:0] d);
      logic [7:0] rx;
      cs_lo(); spi_bits(cmd, 8, rx); spi_bits(d, 8, rx); cs_hi();
   endtask

   task automatic rd1(input logic [7:0] cmd, output logic [7:0] d);
      logic [7:0] rx;
      cs_lo(); spi_bits(cmd, 8, rx); spi_bits(8'h00, 8, d); cs_hi();
   endtask

   initial begin
      repeat (200000 - 50000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] rx;
      int u0;
      for (int k = 0; k < 8; k++)  exp_cal[k] = 8'h00;
      for (int k = 0; k < 31; k++) exp_ram[k] = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state
      check("R1 cal_q", cal_q, 64'h0);
      check("R1 miso", 64'(miso), 64'h0);
      check("R1 upd_stb", 64'(upd_stb), 64'h0);

      // R2 single register writes and reads, indices 0..7 (cmd = idx<<1 | 1)
      for (int i = 0; i < 8; i++) begin
         u0 = upd_cnt;
         exp_cal[i] = 8'((i * 37 + 5) & 255);
         wr1(8'((i << 1) | 1), exp_cal[i]);
         check_cal("R2 write");
         check("R12 one strobe per single write", 64'(upd_cnt - u0), 64'd1);
      end
      for (int i = 0; i < 8; i++) begin
         rd1(8'h81 | 8'(i << 1), rx);
         check("R2 read", 64'(rx), 64'(exp_cal[i]));
      end

      // R3 indices 8..30 ignore writes and read zero
      for (int i = 8; i < 31; i++) begin
         u0 = upd_cnt;
         wr1(8'((i << 1) | 1), 8'hA5);
         check_cal("R3 write ignored");
         check("R3 no strobe", 64'(upd_cnt - u0), 64'd0);
         rd1(8'h81 | 8'(i << 1), rx);
         check("R3 read zero", 64'(rx), 64'h0);
      end

      // R4 write-protect: bit 0 clear
      u0 = upd_cnt;
      wr1(8'h06, 8'hEE);
      check_cal("R4 register protected");
      check("R4 no strobe", 64'(upd_cnt - u0), 64'd0);
      cs_lo(); spi_bits(8'h7E, 8, rx); spi_bits(8'h5A, 8, rx); spi_bits(8'h5B, 8, rx); cs_hi();
      rd1(8'hC1, rx);
      check("R4 scratchpad protected", 64'(rx), 64'(exp_ram[0]));

      // R5 full clock burst write
      u0 = upd_cnt;
      cs_lo(); spi_bits(8'h3F, 8, rx);
      for (int k = 0; k < 8; k++) begin
         exp_cal[k] = 8'(8'h30 + k * 7);
         spi_bits(exp_cal[k], 8, rx);
      end
      cs_hi();
      check_cal("R5 burst commit");
      check("R12 one strobe per burst", 64'(upd_cnt - u0), 64'd1);

      // R6 aborted bursts: seven bytes, then seven and a half bytes
      u0 = upd_cnt;
      cs_lo(); spi_bits(8'h3F, 8, rx);
      for (int k = 0; k < 7; k++) spi_bits(8'hC0 + 8'(k), 8, rx);
      cs_hi();
      check_cal("R6 seven bytes");
      cs_lo(); spi_bits(8'h3F, 8, rx);
      for (int k = 0; k < 7; k++) spi_bits(8'hD0 + 8'(k), 8, rx);
      spi_bits(8'hFF, 4, rx);
      cs_hi();
      check_cal("R6 partial eighth");
      check("R6 no strobe", 64'(upd_cnt - u0), 64'd0);

      // R7 clock burst read, plus one extra byte
      cs_lo(); spi_bits(8'hBF, 8, rx);
      for (int k = 0; k < 9; k++) begin
         spi_bits(8'h00, 8, rx);
         check("R7 burst read", 64'(rx), (k < 8) ? 64'(exp_cal[k]) : 64'h0);
      end
      cs_hi();

      // R8 scratchpad single access sweep (write 41h|idx<<1, read C1h|idx<<1)
      for (int i = 0; i < 31; i++) begin
         exp_ram[i] = 8'((i * 53 + 11) & 255);
         wr1(8'h41 | 8'(i << 1), exp_ram[i]);
      end
      for (int i = 0; i < 31; i++) begin
         rd1(8'hC1 | 8'(i << 1), rx);
         check("R8 scratchpad read", 64'(rx), 64'(exp_ram[i]));
      end

      // R9 scratchpad burst write with partial trailing byte
      u0 = upd_cnt;
      cs_lo(); spi_bits(8'h7F, 8, rx);
      for (int k = 0; k < 3; k++) begin
         exp_ram[k] = 8'hE0 + 8'(k);
         spi_bits(exp_ram[k], 8, rx);
      end
      spi_bits(8'h99, 4, rx);
      cs_hi();
      for (int i = 0; i < 4; i++) begin
         rd1(8'hC1 | 8'(i << 1), rx);
         check("R9 burst stored", 64'(rx), 64'(exp_ram[i]));
      end
      check("R9 no strobe", 64'(upd_cnt - u0), 64'd0);

      // R10 scratchpad burst read over the end
      cs_lo(); spi_bits(8'hFF, 8, rx);
      for (int k = 0; k < 33; k++) begin
         spi_bits(8'h00, 8, rx);
         check("R10 burst read", 64'(rx), (k < 31) ? 64'(exp_ram[k]) : 64'h0);
      end
      cs_hi();

      // R11 parallel load
      u0 = upd_cnt;
      @(negedge clk);
      tk_din = 64'h1122_3344_5566_7788;
      tk_load = 1'b1;
      @(negedge clk);
      tk_load = 1'b0;
      repeat (4) @(negedge clk);
      for (int k = 0; k < 8; k++) exp_cal[k] = tk_din[8*k +: 8];
      check_cal("R11 load");
      check("R11 no strobe", 64'(upd_cnt - u0), 64'd0);
      rd1(8'h85, rx);
      check("R11 bus read", 64'(rx), 64'(exp_cal[2]));

      // R13 abort mid-command, then a clean write
      cs_lo(); spi_bits(8'h00, 5, rx); cs_hi();
      exp_cal[2] = 8'h6C;
      wr1(8'h05, 8'h6C);
      check_cal("R13 after abort");

      check("R12 strobe width", 64'(upd_long), 64'd0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule